// File: doc/BRIEF.md
# Descriptor-Chained Memory Copy Engine

This block is a memory-to-memory copy engine that works through a chain of descriptor nodes held in a small local table. Each node names a source word address, a destination word address, a word count, the index of the next node, an acknowledge address and an acknowledge value. A single pulse on the trigger input starts a walk from the configured head node. A typical trigger source is the completion event of a first-level DMA channel. The engine copies the node's words over a plain read/write memory port. It can then write the acknowledge value to the acknowledge address, which clears the request of the channel that raised the trigger.

Link index 0 means the chain ends there. The node with a null link closes the transfer and raises a chain-complete pulse. A chain whose last node points back to the head runs for as long as the engine is enabled. That suits double-buffered producers: every node after the first waits for its own trigger, so the walk stays in step with the buffer completions. A trigger that arrives while a node is being copied is held as pending, and the next node then starts with no wait. Dropping the enable ends the walk cleanly at the next node boundary.

The controller has seven states:
- IDLE waits for a trigger with enable high, which leads to FETCH.
- FETCH loads the current node. It leads to READ, or for a zero-length node to CLEAR or LINK.
- READ issues one memory read and leads to WRITE.
- WRITE stores that word. It returns to READ, or after the last word moves to CLEAR (non-zero acknowledge value) or LINK (zero value).
- CLEAR performs the acknowledge write and leads to LINK.
- LINK is the node boundary. It leads to IDLE on a null link or low enable, to FETCH on a pending or present trigger, and to WAIT otherwise.
- WAIT holds until a trigger, which leads to FETCH, or until enable falls, which leads to IDLE.

Top module: `chain_dma`

## Requirements
- R1: After reset the engine is idle: `busy`, `mem_re`, `mem_we`, `node_done` and `chain_done` are all low.
- R2: In idle, a cycle with both `trig` and `en` high makes `busy` rise on the next cycle. The cycle after that issues a read at the source address of node `head_idx`.
- R3: A node of length N performs N beats. Beat i is a read cycle at source+i followed in the very next cycle by a write at destination+i. That write carries the `mem_rdata` returned for the read, and no read and write ever share a cycle.
- R4: After a node's last data write, one write of the node's acknowledge value to its acknowledge address follows. It is left out when the acknowledge value is zero.
- R5: `node_done` is a one-cycle pulse in the cycle after a node's final memory write. For a node with no memory writes, it comes in the cycle after its load.
- R6: A node whose link field is 0 raises `chain_done` together with its `node_done`, and the engine is idle in the next cycle.
- R7: A node with a non-zero link is followed by the node of that index. That node starts in the cycle after a trigger if none was pending. If a trigger arrived while the previous node was being loaded, copied or acknowledged, it starts in the cycle after the boundary. At most one trigger is held pending.
- R8: A chain whose links form a cycle never raises `chain_done` while `en` stays high.
- R9: With `en` low, a trigger in idle is ignored. Lowering `en` during a node lets that node finish, including its acknowledge write, and the engine then returns to idle at the boundary.
- R10: A node of length 0 performs no data read or write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable |
| trig | input | 1 | Start / advance pulse |
| head_idx | input | IDX_W | Index of the first node of the chain |
| desc_we | input | 1 | Descriptor table write strobe |
| desc_idx | input | IDX_W | Descriptor slot written |
| desc_src | input | ADDR_W | Node source word address |
| desc_dst | input | ADDR_W | Node destination word address |
| desc_len | input | LEN_W | Node word count |
| desc_link | input | IDX_W | Next node index, 0 = end |
| desc_ack_addr | input | ADDR_W | Node acknowledge address |
| desc_ack_val | input | DATA_W | Node acknowledge value, 0 = no write |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_re` |
| busy | output | 1 | High whenever the engine is not idle |
| node_done | output | 1 | One-cycle pulse per finished node |
| chain_done | output | 1 | One-cycle pulse when a null-link node finishes |

## Verification
The assertions check four things on every cycle:
- a read and a write never share a cycle, and every read is followed at once by a write;
- the node and chain pulses last one cycle, and a chain pulse comes only with a node pulse and leads to idle;
- `busy` rises only after an enabled trigger;
- an idle engine leaves the memory port quiet.

Only the bench's scenarios show the rest:
- the addresses and data of each beat;
- whether the acknowledge write happens or is skipped;
- how far a chain walks, and whether a held trigger saves the wait at a boundary;
- that a looping chain never finishes;
- that an abort takes effect only after the current node.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_READ  = 3'd2,
        ST_WRITE = 3'd3,
        ST_CLEAR = 3'd4,
        ST_LINK  = 3'd5,
        ST_WAIT  = 3'd6
    } walk_state_t;

endpackage

// File: rtl/chain_dma_desc_store.sv
module chain_dma_desc_store #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int NODES  = 8,
    localparam int IDX_W = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_src,
    input  logic [ADDR_W-1:0] wr_dst,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [IDX_W-1:0]  wr_link,
    input  logic [ADDR_W-1:0] wr_ack_addr,
    input  logic [DATA_W-1:0] wr_ack_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_src,
    output logic [ADDR_W-1:0] rd_dst,
    output logic [LEN_W-1:0]  rd_len,
    output logic [IDX_W-1:0]  rd_link,
    output logic [ADDR_W-1:0] rd_ack_addr,
    output logic [DATA_W-1:0] rd_ack_val
);

    // One packed word per node: src | dst | len | link | ack address | ack value
    localparam int WORD_W = 3 * ADDR_W + LEN_W + IDX_W + DATA_W;

    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] slot_rd [NODES];

    assign wr_word = {wr_src, wr_dst, wr_len, wr_link, wr_ack_addr, wr_ack_val};

    for (genvar g = 0; g < NODES; g++) begin : g_slot
        logic [WORD_W-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q <= wr_word;
            end
        end

        assign slot_rd[g] = slot_q;
    end

    assign {rd_src, rd_dst, rd_len, rd_link, rd_ack_addr, rd_ack_val} = slot_rd[rd_idx];

endmodule

// File: rtl/chain_dma_node_regs.sv
module chain_dma_node_regs #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] d_src,
    input  logic [ADDR_W-1:0] d_dst,
    input  logic [LEN_W-1:0]  d_len,
    input  logic [IDX_W-1:0]  d_link,
    input  logic [ADDR_W-1:0] d_ack_addr,
    input  logic [DATA_W-1:0] d_ack_val,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [IDX_W-1:0]  link_q,
    output logic [ADDR_W-1:0] ack_addr_q,
    output logic [DATA_W-1:0] ack_val_q,
    output logic              last_beat,
    output logic              ack_skip,
    output logic              link_null
);

    logic [LEN_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q      <= '0;
            dst_q      <= '0;
            remain_q   <= '0;
            link_q     <= '0;
            ack_addr_q <= '0;
            ack_val_q  <= '0;
        end else if (load) begin
            src_q      <= d_src;
            dst_q      <= d_dst;
            remain_q   <= d_len;
            link_q     <= d_link;
            ack_addr_q <= d_ack_addr;
            ack_val_q  <= d_ack_val;
        end else if (step) begin
            src_q    <= src_q + ADDR_W'(1);
            dst_q    <= dst_q + ADDR_W'(1);
            remain_q <= remain_q - LEN_W'(1);
        end
    end

    assign last_beat = (remain_q == LEN_W'(1));
    assign ack_skip  = (ack_val_q == '0);
    assign link_null = (link_q == '0);

endmodule

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
    import chain_dma_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             trig,
    input  logic [IDX_W-1:0] head_idx,
    input  logic [IDX_W-1:0] link_idx,
    input  logic             fetch_len_zero,
    input  logic             fetch_ack_skip,
    input  logic             last_beat,
    input  logic             ack_skip,
    input  logic             link_null,
    output walk_state_t      state,
    output logic [IDX_W-1:0] cur_idx,
    output logic             load,
    output logic             step
);

    walk_state_t state_q, state_d;
    logic        pend_q;
    logic        in_node;

    assign in_node = (state_q == ST_FETCH) || (state_q == ST_READ) ||
                     (state_q == ST_WRITE) || (state_q == ST_CLEAR);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en && trig) state_d = ST_FETCH;
            ST_FETCH: begin
                if (fetch_len_zero) state_d = fetch_ack_skip ? ST_LINK : ST_CLEAR;
                else                state_d = ST_READ;
            end
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: begin
                if (last_beat) state_d = ack_skip ? ST_LINK : ST_CLEAR;
                else           state_d = ST_READ;
            end
            ST_CLEAR: state_d = ST_LINK;
            ST_LINK: begin
                if (!en || link_null)  state_d = ST_IDLE;
                else if (pend_q || trig) state_d = ST_FETCH;
                else                   state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (!en)       state_d = ST_IDLE;
                else if (trig) state_d = ST_FETCH;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            cur_idx <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_LINK || state_d == ST_IDLE) pend_q <= 1'b0;
            else if (in_node && trig)                    pend_q <= 1'b1;
            if (state_d == ST_FETCH && state_q != ST_FETCH)
                cur_idx <= (state_q == ST_IDLE) ? head_idx : link_idx;
        end
    end

    assign state = state_q;
    assign load  = (state_q == ST_FETCH);
    assign step  = (state_q == ST_WRITE);

endmodule

// File: rtl/chain_dma.sv
module chain_dma
    import chain_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 8,
    parameter int NODES  = 8,
    localparam int IDX_W = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              trig,
    input  logic [IDX_W-1:0]  head_idx,
    input  logic              desc_we,
    input  logic [IDX_W-1:0]  desc_idx,
    input  logic [ADDR_W-1:0] desc_src,
    input  logic [ADDR_W-1:0] desc_dst,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic [IDX_W-1:0]  desc_link,
    input  logic [ADDR_W-1:0] desc_ack_addr,
    input  logic [DATA_W-1:0] desc_ack_val,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              node_done,
    output logic              chain_done
);

    walk_state_t       state;
    logic [IDX_W-1:0]  cur_idx;
    logic              load, step;
    logic [ADDR_W-1:0] f_src, f_dst, f_ack_addr;
    logic [LEN_W-1:0]  f_len;
    logic [IDX_W-1:0]  f_link;
    logic [DATA_W-1:0] f_ack_val;
    logic [ADDR_W-1:0] src_q, dst_q, ack_addr_q;
    logic [IDX_W-1:0]  link_q;
    logic [DATA_W-1:0] ack_val_q;
    logic              last_beat, ack_skip, link_null;

    chain_dma_desc_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .NODES(NODES)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(desc_we), .wr_idx(desc_idx),
        .wr_src(desc_src), .wr_dst(desc_dst), .wr_len(desc_len),
        .wr_link(desc_link), .wr_ack_addr(desc_ack_addr), .wr_ack_val(desc_ack_val),
        .rd_idx(cur_idx),
        .rd_src(f_src), .rd_dst(f_dst), .rd_len(f_len),
        .rd_link(f_link), .rd_ack_addr(f_ack_addr), .rd_ack_val(f_ack_val)
    );

    chain_dma_node_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) u_node (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .d_src(f_src), .d_dst(f_dst), .d_len(f_len), .d_link(f_link),
        .d_ack_addr(f_ack_addr), .d_ack_val(f_ack_val),
        .src_q(src_q), .dst_q(dst_q), .link_q(link_q),
        .ack_addr_q(ack_addr_q), .ack_val_q(ack_val_q),
        .last_beat(last_beat), .ack_skip(ack_skip), .link_null(link_null)
    );

    chain_dma_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .trig(trig),
        .head_idx(head_idx), .link_idx(link_q),
        .fetch_len_zero(f_len == '0), .fetch_ack_skip(f_ack_val == '0),
        .last_beat(last_beat), .ack_skip(ack_skip), .link_null(link_null),
        .state(state), .cur_idx(cur_idx), .load(load), .step(step)
    );

    always_comb begin
        mem_re     = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        node_done  = 1'b0;
        chain_done = 1'b0;
        unique case (state)
            ST_READ: begin
                mem_re   = 1'b1;
                mem_addr = src_q;
            end
            ST_WRITE: begin
                mem_we    = 1'b1;
                mem_addr  = dst_q;
                mem_wdata = mem_rdata;
            end
            ST_CLEAR: begin
                mem_we    = 1'b1;
                mem_addr  = ack_addr_q;
                mem_wdata = ack_val_q;
            end
            ST_LINK: begin
                node_done  = 1'b1;
                chain_done = link_null;
            end
            default: ;
        endcase
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/chain_dma_checker.sv
module chain_dma_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic trig,
    input logic busy,
    input logic mem_re,
    input logic mem_we,
    input logic node_done,
    input logic chain_done
);

    assert_port_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> mem_we);

    assert_node_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        node_done |=> !node_done);

    assert_chain_with_node_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |-> node_done);

    assert_chain_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |=> !busy);

    assert_start_needs_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(trig && en));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_re && !mem_we && !node_done));

endmodule

bind chain_dma chain_dma_checker u_chk (.*);

// File: tb/tb_chain_dma.sv
module tb_chain_dma;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        trig = 1'b0;
    logic [2:0]  head_idx = 3'd1;
    logic        desc_we = 1'b0;
    logic [2:0]  desc_idx = '0;
    logic [15:0] desc_src = '0, desc_dst = '0, desc_ack_addr = '0;
    logic [7:0]  desc_len = '0;
    logic [2:0]  desc_link = '0;
    logic [31:0] desc_ack_val = '0;
    logic        mem_re, mem_we, busy, node_done, chain_done;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    always #5 clk = ~clk;

    chain_dma dut (
        .clk(clk), .rst_n(rst_n), .en(en), .trig(trig), .head_idx(head_idx),
        .desc_we(desc_we), .desc_idx(desc_idx), .desc_src(desc_src),
        .desc_dst(desc_dst), .desc_len(desc_len), .desc_link(desc_link),
        .desc_ack_addr(desc_ack_addr), .desc_ack_val(desc_ack_val),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .node_done(node_done), .chain_done(chain_done)
    );

    // Memory model, one-cycle read latency
    logic [31:0] mem  [256];
    logic [31:0] orig [256];
    initial for (int i = 0; i < 256; i++) begin
        mem[i]  = 32'hA000_0000 + 32'(i);
        orig[i] = 32'hA000_0000 + 32'(i);
    end
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end

    int total = 0, bad = 0;
    int nd_cnt = 0, cd_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Shadow of the descriptor table
    int t_src[8], t_dst[8], t_len[8], t_link[8], t_aa[8], t_av[8];

    // Behavioural cycle model: phase 0 idle,1 load,2 read,3 write,4 ack,5 boundary,6 wait
    int ph, cur, m_src, m_dst, m_rem, m_link, m_aa, m_av;
    bit m_pend;
    logic [31:0] m_data;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph = 0; m_pend = 0; cur = 0; m_src = 0; m_dst = 0; m_rem = 0;
            m_link = 0; m_aa = 0; m_av = 0; m_data = '0;
        end else begin
            automatic int old = ph;
            case (ph)
                0: if (en && trig) begin cur = int'(head_idx); ph = 1; end
                1: begin
                    m_src = t_src[cur]; m_dst = t_dst[cur]; m_rem = t_len[cur];
                    m_link = t_link[cur]; m_aa = t_aa[cur]; m_av = t_av[cur];
                    ph = (m_rem == 0) ? ((m_av != 0) ? 4 : 5) : 2;
                end
                2: begin m_data = mem[m_src[7:0]]; ph = 3; end
                3: begin
                    m_src++; m_dst++; m_rem--;
                    ph = (m_rem == 0) ? ((m_av != 0) ? 4 : 5) : 2;
                end
                4: ph = 5;
                5: begin
                    if (!en || m_link == 0) ph = 0;
                    else if (m_pend || trig) begin cur = m_link; ph = 1; end
                    else ph = 6;
                    m_pend = 0;
                end
                6: begin
                    if (!en) ph = 0;
                    else if (trig) begin cur = m_link; ph = 1; end
                end
                default: ph = 0;
            endcase
            if (old >= 1 && old <= 4 && trig) m_pend = 1;
        end
    end

    // Compare every cycle away from the active edge
    always @(negedge clk) if (rst_n) begin
        chk(busy == (ph != 0), "R2/R9", "busy", busy, ph != 0);
        chk(mem_re == (ph == 2), "R3/R10", "mem_re", mem_re, ph == 2);
        chk(mem_we == (ph == 3 || ph == 4), "R3/R4", "mem_we", mem_we, ph == 3 || ph == 4);
        if (ph == 2) chk(mem_addr == 16'(m_src), "R3", "read addr", mem_addr, m_src);
        if (ph == 3) begin
            chk(mem_addr == 16'(m_dst), "R3", "write addr", mem_addr, m_dst);
            chk(mem_wdata == m_data, "R3", "write data", mem_wdata, m_data);
        end
        if (ph == 4) begin
            chk(mem_addr == 16'(m_aa), "R4", "ack addr", mem_addr, m_aa);
            chk(mem_wdata == 32'(m_av), "R4", "ack value", mem_wdata, m_av);
        end
        chk(node_done == (ph == 5), "R5", "node_done", node_done, ph == 5);
        chk(chain_done == (ph == 5 && m_link == 0), "R6/R8", "chain_done",
            chain_done, ph == 5 && m_link == 0);
        if (node_done) nd_cnt++;
        if (chain_done) cd_cnt++;
    end

    task automatic wr_desc(input int i, s, d, l, k, aa, av);
        t_src[i] = s; t_dst[i] = d; t_len[i] = l; t_link[i] = k; t_aa[i] = aa; t_av[i] = av;
        @(negedge clk);
        desc_we = 1; desc_idx = 3'(i); desc_src = 16'(s); desc_dst = 16'(d);
        desc_len = 8'(l); desc_link = 3'(k); desc_ack_addr = 16'(aa); desc_ack_val = 32'(av);
        @(negedge clk);
        desc_we = 0;
    endtask

    task automatic pulse();
        @(negedge clk) trig = 1;
        @(negedge clk) trig = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    bit finished = 0;
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(0, "ALL", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            t_src[i] = 0; t_dst[i] = 0; t_len[i] = 0; t_link[i] = 0; t_aa[i] = 0; t_av[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !mem_re && !mem_we && !node_done && !chain_done, "R1", "reset outputs",
            {busy, mem_re, mem_we, node_done, chain_done}, 0);
        rst_n = 1;
        idle(2);
        // R9: trigger while disabled is ignored
        pulse(); idle(4);
        chk(!busy, "R9", "trigger with en low", busy, 0);

        // Chain 1 -> 2 -> 3(null), node 3 zero length without ack (R10)
        wr_desc(1, 'h10, 'h40, 3, 2, 'hF0, 1);
        wr_desc(2, 'h20, 'h50, 1, 3, 'hF0, 2);
        wr_desc(3, 'h28, 'h58, 0, 0, 'hF1, 0);
        en = 1;
        nd_cnt = 0; cd_cnt = 0;
        pulse(); idle(15);
        chk(busy, "R7", "waiting for next trigger", busy, 1);
        pulse(); idle(15);
        pulse(); idle(10);
        for (int i = 0; i < 3; i++)
            chk(mem[8'h40 + i] == orig[8'h10 + i], "R3", "node1 copy", mem[8'h40 + i], orig[8'h10 + i]);
        chk(mem[8'h50] == orig[8'h20], "R3", "node2 copy", mem[8'h50], orig[8'h20]);
        chk(mem[8'hF0] == 32'd2, "R4", "ack word", mem[8'hF0], 2);
        chk(mem[8'hF1] == orig[8'hF1], "R4", "skipped ack", mem[8'hF1], orig[8'hF1]);
        chk(mem[8'h58] == orig[8'h58], "R10", "zero length dst", mem[8'h58], orig[8'h58]);
        chk(nd_cnt == 3, "R5", "node count", nd_cnt, 3);
        chk(cd_cnt == 1, "R6", "chain count", cd_cnt, 1);
        chk(!busy, "R6", "idle after chain", busy, 0);

        // R7: triggers during node 1 are held (two arrive, one kept)
        nd_cnt = 0; cd_cnt = 0;
        pulse(); idle(1); pulse(); pulse(); idle(20);
        chk(nd_cnt == 2, "R7", "pending advanced one node", nd_cnt, 2);
        pulse(); idle(10);
        chk(cd_cnt == 1 && !busy, "R7", "chain end after third", cd_cnt, 1);

        // R8: looping chain 4 <-> 5
        head_idx = 3'd4;
        wr_desc(4, 'h60, 'h80, 2, 5, 'hF2, 4);
        wr_desc(5, 'h68, 'h88, 2, 4, 'hF3, 8);
        nd_cnt = 0; cd_cnt = 0;
        for (int k = 0; k < 6; k++) begin pulse(); idle(14); end
        chk(cd_cnt == 0, "R8", "loop never ends", cd_cnt, 0);
        chk(nd_cnt == 6, "R8", "loop node count", nd_cnt, 6);
        chk(busy, "R8", "loop still active", busy, 1);
        chk(mem[8'h88] == orig[8'h68] && mem[8'hF3] == 32'd8, "R8", "loop copy",
            mem[8'h88], orig[8'h68]);

        // R9: abort mid-node finishes the node then idles
        pulse(); idle(1);
        en = 0;
        idle(14);
        chk(nd_cnt == 7, "R9", "aborted node completed", nd_cnt, 7);
        chk(!busy, "R9", "idle after abort", busy, 0);
        chk(mem[8'hF2] == 32'd4, "R9", "abort ack written", mem[8'hF2], 4);
        pulse(); idle(4);
        chk(!busy, "R9", "trigger after abort ignored", busy, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule